// File: doc/BRIEF.md
# Vector Extension Prefix Stream Decoder

This block sits in an instruction fetch path and takes instruction bytes one per cycle over a valid/ready handshake. It finds the compact vector-extension prefix, which comes in a two-byte form led by `C5` and a three-byte form led by `C4`. The prefix bytes are consumed. The opcode byte that follows comes out with a decoded record attached: the register-extension bits, the operand-width bit, the second-source register number, the vector length, the implied legacy prefix, the implied escape map, a reserved-map error flag and the prefix length. Every other byte passes through unchanged, with the record fields at zero.

A mode input selects 32-bit or 64-bit operation. In 64-bit mode a `C4` or `C5` byte always opens a prefix. In 32-bit mode the same two values are also the legacy load-far-pointer opcodes, so the decoder looks at the following byte before it consumes it. It treats the pair as a prefix only when bits 7:6 of that byte are both one. Otherwise it sends the lead byte on as a plain byte and returns to idle, where the looked-at byte is handled normally. A single output register isolates the downstream side.

Top module: `vxp_stream_decoder`

## Requirements
- R1: A byte that is not part of a prefix leaves on `out_data` unchanged and in arrival order, with `out_prefixed`=0 and `out_len`, `out_r`, `out_x`, `out_b`, `out_w`, `out_vsrc`, `out_wide`, `out_pfx`, `out_map` and `out_map_err` all 0.
- R2: With `mode_64`=1, `C4` and `C5` always open a prefix. The prefix bytes are not emitted. The next byte is emitted with `out_prefixed`=1 and its record. The decoder then returns to idle, so a following `C4`/`C5` opens a new prefix.
- R3: With `mode_64`=0, a `C4`/`C5` byte opens a prefix only if bits 7:6 of the next byte are `11`. Otherwise both bytes leave unchanged as plain bytes (R1), in order.
- R4: Three-byte form (`C4`, P1, P2): `out_r`=~P1[7], `out_x`=~P1[6], `out_b`=~P1[5], `out_w`=P2[7], `out_vsrc`=~P2[6:3], `out_wide`=P2[2], `out_pfx`=P2[1:0], `out_len`=3.
- R5: Two-byte form (`C5`, P1): `out_r`=~P1[7], `out_vsrc`=~P1[6:3], `out_wide`=P1[2], `out_pfx`=P1[1:0], `out_x`=`out_b`=`out_w`=0, `out_map`=1, `out_map_err`=0, `out_len`=2.
- R6: The five-bit map field P1[4:0] of the three-byte form gives `out_map` = field for 1 (0F), 2 (0F 38) and 3 (0F 3A), with `out_map_err`=0. Any other value (0, 4 to 31) gives `out_map`=0 and `out_map_err`=1.
- R7: An all-ones second-source field (unused) decodes to `out_vsrc`=0.
- R8: `out_pfx` codes 0, 1, 2, 3 stand for no prefix, 66, F3 and F2. `out_wide`=0 means 128-bit and 1 means 256-bit vectors.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` and the record hold still. No byte is lost or duplicated under any stall pattern.
- R10: While reset is asserted and after it is released, `out_valid`=0 and `in_ready`=1 until the first byte arrives, and the decoder starts in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input instruction byte |
| in_ready | output | 1 | Decoder accepts the input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte (opcode or plain byte) |
| out_prefixed | output | 1 | Byte carries a decoded prefix record |
| out_len | output | 2 | Prefix length in bytes (2, 3, or 0) |
| out_r | output | 1 | Register-operand extension bit |
| out_x | output | 1 | Index extension bit |
| out_b | output | 1 | Base extension bit |
| out_w | output | 1 | Operand-width / opcode-extension bit |
| out_vsrc | output | 4 | Second-source register number |
| out_wide | output | 1 | Vector length: 0 = 128, 1 = 256 bits |
| out_pfx | output | 2 | Implied legacy prefix code |
| out_map | output | 2 | Escape map code: 1 = 0F, 2 = 0F 38, 3 = 0F 3A, 0 = reserved |
| out_map_err | output | 1 | Reserved map value seen |

## Verification
A state register stuck in the second-byte or third-byte state swallows the next byte. The output stream then comes up one byte short within two transfers of the lead byte, and the byte that is finally emitted carries `out_prefixed`=1 where a plain byte was expected. A lost pass-through state shows up on the first opcode as a missing record. A faulty lookahead in 32-bit mode shows up as a missing `C4`/`C5` byte in the output stream, or as an extra one. A held byte that changes under a stall is visible on the next sampled cycle. A record field wired to the wrong bit or polarity shows up on the very opcode that carries it.

// File: rtl/vxp_pkg.sv
package vxp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SECOND = 2'd1,
    ST_THIRD  = 2'd2,
    ST_PASS   = 2'd3
  } vxp_state_e;

  localparam logic [1:0] MAP_RSVD = 2'd0;
  localparam logic [1:0] MAP_ESC1 = 2'd1;
  localparam logic [1:0] MAP_ESC2 = 2'd2;
  localparam logic [1:0] MAP_ESC3 = 2'd3;

  typedef struct packed {
    logic       r;
    logic       x;
    logic       b;
    logic       w;
    logic [3:0] vsrc;
    logic       wide;
    logic [1:0] pfx;
    logic [1:0] map;
    logic       map_err;
    logic [1:0] plen;
  } vxp_rec_t;

endpackage

// File: rtl/vxp_rst_sync.sv
module vxp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/vxp_lead_detect.sv
module vxp_lead_detect #(
  parameter logic [7:0] LEAD_THREE = 8'hC4,
  parameter logic [7:0] LEAD_TWO   = 8'hC5,
  parameter logic [1:0] TAG_BITS   = 2'b11
) (
  input  logic [7:0] byte_in,
  input  logic       mode_64,
  output logic       hit_lead,
  output logic       hit_three,
  output logic       follow_ok
);
  always_comb begin
    hit_three = (byte_in == LEAD_THREE);
    hit_lead  = hit_three || (byte_in == LEAD_TWO);
    follow_ok = mode_64 || (byte_in[7:6] == TAG_BITS);
  end
endmodule

// File: rtl/vxp_field_unpack.sv
module vxp_field_unpack
  import vxp_pkg::*;
(
  input  logic       three_form,
  input  logic [7:0] byte_a,
  input  logic [7:0] byte_b,
  output vxp_rec_t   rec
);
  logic [4:0] map_raw;
  logic       map_known;

  always_comb begin
    map_raw   = byte_a[4:0];
    map_known = (map_raw == 5'd1) || (map_raw == 5'd2) || (map_raw == 5'd3);
    rec       = '0;
    rec.r     = ~byte_a[7];
    if (three_form) begin
      rec.x       = ~byte_a[6];
      rec.b       = ~byte_a[5];
      rec.w       = byte_b[7];
      rec.vsrc    = ~byte_b[6:3];
      rec.wide    = byte_b[2];
      rec.pfx     = byte_b[1:0];
      rec.map     = map_known ? map_raw[1:0] : MAP_RSVD;
      rec.map_err = !map_known;
      rec.plen    = 2'd3;
    end else begin
      rec.vsrc    = ~byte_a[6:3];
      rec.wide    = byte_a[2];
      rec.pfx     = byte_a[1:0];
      rec.map     = MAP_ESC1;
      rec.plen    = 2'd2;
    end
  end
endmodule

// File: rtl/vxp_stream_decoder.sv
module vxp_stream_decoder
  import vxp_pkg::*;
#(
  parameter logic [7:0] LEAD_THREE = 8'hC4,
  parameter logic [7:0] LEAD_TWO   = 8'hC5,
  parameter int         RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_64,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_prefixed,
  output logic [1:0] out_len,
  output logic       out_r,
  output logic       out_x,
  output logic       out_b,
  output logic       out_w,
  output logic [3:0] out_vsrc,
  output logic       out_wide,
  output logic [1:0] out_pfx,
  output logic [1:0] out_map,
  output logic       out_map_err
);
  logic srst_n;

  vxp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  vxp_state_e state_q, state_d;
  logic       three_q;
  logic [7:0] sec_q;
  vxp_rec_t   rec_q;
  logic       ov_q;
  logic [7:0] od_q;
  logic       opref_q;
  vxp_rec_t   orec_q;

  logic       hit_lead, hit_three, follow_ok;
  logic [7:0] byte_a;
  vxp_rec_t   rec_new;

  vxp_lead_detect #(
    .LEAD_THREE(LEAD_THREE), .LEAD_TWO(LEAD_TWO), .TAG_BITS(2'b11)
  ) u_lead (
    .byte_in(in_data), .mode_64(mode_64),
    .hit_lead(hit_lead), .hit_three(hit_three), .follow_ok(follow_ok)
  );

  assign byte_a = (state_q == ST_THIRD) ? sec_q : in_data;

  vxp_field_unpack u_unpack (
    .three_form(three_q), .byte_a(byte_a), .byte_b(in_data), .rec(rec_new)
  );

  logic       out_free;
  logic       ld_out, ld_three, ld_sec, ld_rec;
  logic [7:0] out_byte_d;
  logic       out_pref_d;
  vxp_rec_t   out_rec_d;

  always_comb begin
    out_free   = !ov_q || out_ready;
    state_d    = state_q;
    in_ready   = 1'b0;
    ld_out     = 1'b0;
    ld_three   = 1'b0;
    ld_sec     = 1'b0;
    ld_rec     = 1'b0;
    out_byte_d = in_data;
    out_pref_d = 1'b0;
    out_rec_d  = '0;
    unique case (state_q)
      ST_IDLE: begin
        in_ready = out_free;
        if (in_valid && out_free) begin
          if (hit_lead) begin
            ld_three = 1'b1;
            state_d  = ST_SECOND;
          end else begin
            ld_out = 1'b1;
          end
        end
      end
      ST_SECOND: begin
        in_ready = follow_ok;
        if (in_valid) begin
          if (follow_ok) begin
            if (three_q) begin
              ld_sec  = 1'b1;
              state_d = ST_THIRD;
            end else begin
              ld_rec  = 1'b1;
              state_d = ST_PASS;
            end
          end else if (out_free) begin
            ld_out     = 1'b1;
            out_byte_d = three_q ? LEAD_THREE : LEAD_TWO;
            state_d    = ST_IDLE;
          end
        end
      end
      ST_THIRD: begin
        in_ready = 1'b1;
        if (in_valid) begin
          ld_rec  = 1'b1;
          state_d = ST_PASS;
        end
      end
      ST_PASS: begin
        in_ready = out_free;
        if (in_valid && out_free) begin
          ld_out     = 1'b1;
          out_pref_d = 1'b1;
          out_rec_d  = rec_q;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      three_q <= 1'b0;
      sec_q   <= '0;
      rec_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ld_three) three_q <= hit_three;
      if (ld_sec)   sec_q   <= in_data;
      if (ld_rec)   rec_q   <= rec_new;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ov_q    <= 1'b0;
      od_q    <= '0;
      opref_q <= 1'b0;
      orec_q  <= '0;
    end else begin
      if (ld_out) begin
        ov_q    <= 1'b1;
        od_q    <= out_byte_d;
        opref_q <= out_pref_d;
        orec_q  <= out_rec_d;
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
    end
  end

  assign out_valid    = ov_q;
  assign out_data     = od_q;
  assign out_prefixed = opref_q;
  assign out_len      = orec_q.plen;
  assign out_r        = orec_q.r;
  assign out_x        = orec_q.x;
  assign out_b        = orec_q.b;
  assign out_w        = orec_q.w;
  assign out_vsrc     = orec_q.vsrc;
  assign out_wide     = orec_q.wide;
  assign out_pfx      = orec_q.pfx;
  assign out_map      = orec_q.map;
  assign out_map_err  = orec_q.map_err;
endmodule

// File: rtl/vxp_stream_checker.sv
module vxp_stream_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_prefixed,
  input logic [1:0] out_len,
  input logic       out_r,
  input logic       out_x,
  input logic       out_b,
  input logic       out_w,
  input logic [3:0] out_vsrc,
  input logic       out_wide,
  input logic [1:0] out_pfx,
  input logic [1:0] out_map,
  input logic       out_map_err
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_prefixed)
                                   && $stable(out_vsrc) && $stable(out_len)));

  p_plain_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_prefixed) |-> (out_len == 2'd0 && !out_r && !out_x && !out_b && !out_w
      && out_vsrc == 4'd0 && !out_wide && out_pfx == 2'd0 && out_map == 2'd0 && !out_map_err));

  p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_prefixed) |-> (out_len == 2'd2 || out_len == 2'd3));

  p_two_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == 2'd2) |-> (!out_x && !out_b && !out_w && out_map == 2'd1 && !out_map_err));

  p_map_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_prefixed) |-> (out_map_err == (out_map == 2'd0)));
endmodule

bind vxp_stream_decoder vxp_stream_checker u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_prefixed(out_prefixed), .out_len(out_len),
  .out_r(out_r), .out_x(out_x), .out_b(out_b), .out_w(out_w),
  .out_vsrc(out_vsrc), .out_wide(out_wide), .out_pfx(out_pfx),
  .out_map(out_map), .out_map_err(out_map_err)
);

// File: tb/tb_vxp_stream_decoder.sv
`timescale 1ns/1ps
module tb_vxp_stream_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_64 = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_prefixed, out_r, out_x, out_b, out_w, out_wide, out_map_err;
  logic [1:0] out_len, out_pfx, out_map;
  logic [3:0] out_vsrc;

  always #4 clk = ~clk;

  vxp_stream_decoder dut (
    .clk(clk), .rst_n(rst_n), .mode_64(mode_64), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_prefixed(out_prefixed), .out_len(out_len), .out_r(out_r), .out_x(out_x),
    .out_b(out_b), .out_w(out_w), .out_vsrc(out_vsrc), .out_wide(out_wide),
    .out_pfx(out_pfx), .out_map(out_map), .out_map_err(out_map_err)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [24:0] obs_q [64];
  logic [24:0] exp_q [64];
  int n_obs = 0;
  int n_exp = 0;
  logic       hold_pend = 1'b0;
  logic [7:0] hold_data = 8'h00;
  logic       done = 1'b0;

  function automatic logic [24:0] e_plain(input logic [7:0] d);
    return {d, 1'b0, 2'd0, 4'b0000, 4'd0, 1'b0, 2'd0, 2'd0, 1'b0};
  endfunction

  function automatic logic [24:0] e_three(input logic [7:0] p1, input logic [7:0] p2,
                                          input logic [7:0] op);
    logic [4:0] m;
    logic       ok;
    m  = p1[4:0];
    ok = (m >= 5'd1) && (m <= 5'd3);
    return {op, 1'b1, 2'd3, ~p1[7], ~p1[6], ~p1[5], p2[7], ~p2[6:3], p2[2], p2[1:0],
            ok ? m[1:0] : 2'd0, ~ok};
  endfunction

  function automatic logic [24:0] e_two(input logic [7:0] p1, input logic [7:0] op);
    return {op, 1'b1, 2'd2, ~p1[7], 1'b0, 1'b0, 1'b0, ~p1[6:3], p1[2], p1[1:0], 2'd1, 1'b0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        check(out_valid && out_data == hold_data, "R9 hold under stall",
              {23'd0, out_valid, out_data}, {23'd0, 1'b1, hold_data});
      hold_pend = out_valid && !out_ready;
      hold_data = out_data;
      if (out_valid && out_ready && n_obs < 64) begin
        obs_q[n_obs] = {out_data, out_prefixed, out_len, out_r, out_x, out_b, out_w,
                        out_vsrc, out_wide, out_pfx, out_map, out_map_err};
        n_obs++;
      end
    end
  end

  task automatic expect_rec(input logic [24:0] v);
    exp_q[n_exp] = v;
    n_exp++;
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  task automatic begin_case(input logic m64);
    n_obs   = 0;
    n_exp   = 0;
    mode_64 = m64;
  endtask

  task automatic finish_case(input string req);
    repeat (6) @(posedge clk);
    #2;
    check(n_obs == n_exp, {req, " byte count"}, n_obs, n_exp);
    for (int i = 0; i < n_exp && i < n_obs; i++)
      check(obs_q[i] == exp_q[i], req, {7'd0, obs_q[i]}, {7'd0, exp_q[i]});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(!out_valid && in_ready, "R10 during reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check(!out_valid && in_ready, "R10 after release", {out_valid, in_ready}, 2'b01);
  endtask

  task automatic t_plain;
    begin_case(1'b0);
    push(8'h90); push(8'h0F); push(8'h58); push(8'h00);
    expect_rec(e_plain(8'h90)); expect_rec(e_plain(8'h0F));
    expect_rec(e_plain(8'h58)); expect_rec(e_plain(8'h00));
    finish_case("R1 plain bytes");
  endtask

  task automatic t_three_64;
    begin_case(1'b1);
    push(8'hC4); push(8'hE1); push(8'h7D); push(8'h58);
    expect_rec(e_three(8'hE1, 8'h7D, 8'h58));
    push(8'hC4); push(8'h02); push(8'hB0); push(8'hF7);
    expect_rec(e_three(8'h02, 8'hB0, 8'hF7));
    push(8'hC4); push(8'h43); push(8'hCA); push(8'h0C);
    expect_rec(e_three(8'h43, 8'hCA, 8'h0C));
    push(8'h90);
    expect_rec(e_plain(8'h90));
    finish_case("R2 R4 R7 three-byte form in 64-bit mode");
  endtask

  task automatic t_two;
    begin_case(1'b1);
    push(8'hC5); push(8'hF8); push(8'h28);
    expect_rec(e_two(8'hF8, 8'h28));
    push(8'hC5); push(8'h45); push(8'h10);
    expect_rec(e_two(8'h45, 8'h10));
    finish_case("R5 R7 two-byte form");
  endtask

  task automatic t_pfx;
    begin_case(1'b1);
    for (int k = 0; k < 4; k++) begin
      push(8'hC5); push({1'b1, 4'b1111, k[0], k[1:0]}); push(8'h51);
      expect_rec(e_two({1'b1, 4'b1111, k[0], k[1:0]}, 8'h51));
    end
    finish_case("R8 prefix codes and length bit");
  endtask

  task automatic t_mode32;
    begin_case(1'b0);
    push(8'hC4); push(8'h06); push(8'h90);
    expect_rec(e_plain(8'hC4)); expect_rec(e_plain(8'h06)); expect_rec(e_plain(8'h90));
    push(8'hC5); push(8'h80);
    expect_rec(e_plain(8'hC5)); expect_rec(e_plain(8'h80));
    push(8'hC5); push(8'hC0); push(8'h77);
    expect_rec(e_two(8'hC0, 8'h77));
    push(8'hC4); push(8'hE2); push(8'h79); push(8'h18);
    expect_rec(e_three(8'hE2, 8'h79, 8'h18));
    finish_case("R3 32-bit lookahead");
  endtask

  task automatic t_maps;
    begin_case(1'b1);
    push(8'hC4); push(8'hE0); push(8'h78); push(8'h11);
    expect_rec(e_three(8'hE0, 8'h78, 8'h11));
    push(8'hC4); push(8'hE4); push(8'h78); push(8'h12);
    expect_rec(e_three(8'hE4, 8'h78, 8'h12));
    push(8'hC4); push(8'hFF); push(8'h78); push(8'h13);
    expect_rec(e_three(8'hFF, 8'h78, 8'h13));
    push(8'hC4); push(8'hE3); push(8'h78); push(8'h14);
    expect_rec(e_three(8'hE3, 8'h78, 8'h14));
    finish_case("R6 escape map decode");
  endtask

  task automatic t_stall;
    begin_case(1'b0);
    fork
      begin
        push(8'h33); push(8'hC4); push(8'h21); push(8'h90);
        push(8'hC4); push(8'hE1); push(8'h7D); push(8'h58);
        push(8'h44); push(8'h55);
      end
      begin
        for (int k = 0; k < 40; k++) begin
          @(posedge clk);
          #2;
          out_ready = (k % 3) != 0;
        end
        out_ready = 1'b1;
      end
    join
    out_ready = 1'b1;
    expect_rec(e_plain(8'h33)); expect_rec(e_plain(8'hC4)); expect_rec(e_plain(8'h21));
    expect_rec(e_plain(8'h90)); expect_rec(e_three(8'hE1, 8'h7D, 8'h58));
    expect_rec(e_plain(8'h44)); expect_rec(e_plain(8'h55));
    finish_case("R9 order under backpressure");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    #2;
    t_reset();
    t_plain();
    t_three_64();
    t_two();
    t_pfx();
    t_mode32();
    t_maps();
    t_stall();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule